// File: doc/BRIEF.md
# Balancing Abort Arbiter with Stop-Event Log

This block sits between the fault detectors of a multi-cell pack and the balance switch drivers. It watches every condition that must halt passive balancing at once, decides whether the halt covers one cell, one thermal zone or every channel, and drives three disable outputs for the switch stage. Whenever a disable newly takes hold, it writes a short record to a small FIFO. The record says which channel was open, when that channel opened, when the stop happened, why it stopped and at what level.

The global disable is sticky. It releases only when the clear request (an explicit clear strobe, or the start of constant-voltage charging) arrives while no global source is active. Local and zone disables also latch, and a clear request releases them once their cell faults have gone. Cells belong to zone `i mod N_ZONE`, so with two zones the even cells share one zone and the odd cells share the other.

The log leaves the block on a valid/ready stream. A record stays on the outputs for as long as `log_valid` is high and `log_ready` is low, and it is removed on a clock edge where both are high. The block never waits for the reader. When the FIFO already holds `LOG_DEPTH` records, a new record is dropped and a sticky overflow flag is raised.

Top module: `bal_abort_arbiter`

## Requirements
- R1: After reset `loc_dis`, `zone_dis`, `glob_dis`, `log_valid` and `log_ovf` are all 0, provided the inputs show the charger present, no fault, and heartbeat pulses.
- R2: Six conditions act as global sources: charger absent, input undervoltage, critical temperature, charger fault, heartbeat lost and service mode. If any of them is sampled at a clock edge, `glob_dis` is 1 after that edge.
- R3: When several global sources start together, the logged reason follows a fixed priority from highest to lowest, with these codes: charger absent or input undervoltage 1, critical temperature 2, charger fault 3, heartbeat lost 4, service mode 5. Cell faults log reason code 6.
- R4: Once set, `glob_dis` holds until a clear request (`glob_clr` or `cv_entry`) is sampled while no global source is active. A clear request sampled while any global source is active has no effect.
- R5: The heartbeat counter restarts on each sampled `hb_pulse`. The heartbeat-lost source becomes active once `hb_limit` cycles have passed without a pulse. As a result, `glob_dis` rises `hb_limit+1` edges after the edge that sampled the last pulse.
- R6: With `zone_widen` at 0, a cell fault (over-voltage, under-voltage or bad read) sets that cell's bit in `loc_dis` after one edge, and `zone_dis` is left untouched. A clear request releases the bit only if that cell's fault is gone.
- R7: With `zone_widen` at 1, a cell fault instead sets `zone_dis` for every channel whose index has the same value mod `N_ZONE`. `loc_dis` stays 0.
- R8: Each record holds five fields: channel, start timestamp, stop timestamp, reason and level. The level codes are 1 for local, 2 for zone and 3 for global. The stop timestamp is `ts_now` at the edge where the disable takes hold. For a global stop, the channel is the lowest enabled channel, or `N_CELL` if none is enabled. The start timestamp is `ts_now` at the edge that sampled that channel's enable rising, or 0 if the channel was never enabled.
- R9: At most one record is written per edge, and only when a disable newly takes hold. A new global stop takes precedence over cell events. Among cells that fault in the same cycle, only the lowest index is logged.
- R10: Log records come out in write order. A record is held stable while `log_valid` is 1 and `log_ready` is 0.
- R11: With `LOG_DEPTH` records stored, a new record is dropped and `log_ovf` is set. `log_ovf` then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chg_present | input | 1 | Charger is connected |
| chg_fault | input | 1 | Charger reports a fault |
| in_uvlo | input | 1 | Input undervoltage |
| temp_crit | input | 1 | Board temperature above the critical threshold |
| svc_mode | input | 1 | Service or shipping mode |
| cv_entry | input | 1 | Constant-voltage phase entered; acts as a clear request |
| hb_pulse | input | 1 | Host heartbeat |
| hb_limit | input | HB_W | Heartbeat timeout in cycles |
| zone_widen | input | 1 | Widen cell faults to their zone |
| glob_clr | input | 1 | Clear request |
| cell_ov | input | N_CELL | Per-cell over-voltage |
| cell_uv | input | N_CELL | Per-cell under-voltage |
| cell_bad | input | N_CELL | Per-cell bad reading |
| ch_en | input | N_CELL | Channels currently balancing |
| ts_now | input | TS_W | Timestamp counter |
| loc_dis | output | N_CELL | Per-cell disable |
| zone_dis | output | N_CELL | Per-channel disable caused by a zone stop |
| glob_dis | output | 1 | Disable of all channels |
| log_valid | output | 1 | Log record available |
| log_ready | input | 1 | Reader accepts the record |
| log_chan | output | $clog2(N_CELL+1) | Record: channel |
| log_start | output | TS_W | Record: start timestamp |
| log_stop | output | TS_W | Record: stop timestamp |
| log_reason | output | 3 | Record: reason code |
| log_level | output | 2 | Record: level code |
| log_ovf | output | 1 | Sticky log overflow |

## Verification
Every disable output and every log record is due one edge after the edge that samples its cause. The exception is the heartbeat path, which takes `hb_limit+1` edges after the last sampled pulse. The bench drives each stimulus 1 ns after a rising edge, moves forward exactly the number of edges due, and reads the outputs at that moment. Expected records are queued when the stimulus is applied, using the timestamp the design will sample at the next edge. A falling-edge monitor compares each record that is accepted, so stalls under back-pressure and drops on a full FIFO show up as missing or extra records.

// File: rtl/bal_abort_pkg.sv
package bal_abort_pkg;
  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_CHG_GONE  = 3'd1,
    RSN_OVERTEMP  = 3'd2,
    RSN_CHG_FAULT = 3'd3,
    RSN_HB_LOST   = 3'd4,
    RSN_SERVICE   = 3'd5,
    RSN_CELL      = 3'd6
  } rsn_e;

  typedef enum logic [1:0] {
    LVL_NONE   = 2'd0,
    LVL_LOCAL  = 2'd1,
    LVL_GROUP  = 2'd2,
    LVL_GLOBAL = 2'd3
  } lvl_e;

  // global source vector, bit 0 = highest priority
  localparam int NUM_GSRC = 5;
endpackage

// File: rtl/bal_hb_watch.sv
module bal_hb_watch #(
  parameter int HB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hb_pulse,
  input  logic [HB_W-1:0] hb_limit,
  output logic            hb_lost
);
  logic [HB_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (hb_pulse)         cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  assign hb_lost = (cnt_q >= hb_limit);

  AST_HB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hb_pulse && (hb_limit != '0) |=> !hb_lost || (hb_limit == '0)); // R5
endmodule

// File: rtl/bal_shut_latch.sv
module bal_shut_latch
  import bal_abort_pkg::*;
#(
  parameter int N_CELL = 6,
  parameter int N_ZONE = 2,
  parameter int CW     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GSRC-1:0] glob_src,
  input  logic [N_CELL-1:0]   cell_flt,
  input  logic                widen,
  input  logic                clr_req,
  output logic                glob_dis,
  output logic [N_CELL-1:0]   loc_dis,
  output logic [N_CELL-1:0]   zone_dis,
  output logic                glob_new,
  output rsn_e                glob_rsn,
  output logic                cell_new,
  output logic [CW-1:0]       cell_idx,
  output lvl_e                cell_lvl
);
  logic                glob_q;
  logic [N_CELL-1:0]   loc_q;
  logic [N_ZONE-1:0]   zone_q, zone_flt;
  logic [N_CELL-1:0]   fresh;
  logic                any_src;

  assign any_src = |glob_src;

  always_comb begin
    glob_rsn = RSN_NONE;
    for (int k = NUM_GSRC-1; k >= 0; k--)
      if (glob_src[k]) glob_rsn = rsn_e'(3'(k+1));
  end

  always_comb begin
    zone_flt = '0;
    for (int z = 0; z < N_ZONE; z++)
      for (int i = 0; i < N_CELL; i++)
        if ((i % N_ZONE) == z && cell_flt[i]) zone_flt[z] = 1'b1;
  end

  always_comb begin
    cell_idx = '0;
    for (int i = 0; i < N_CELL; i++) begin
      fresh[i]    = widen ? (cell_flt[i] & ~zone_q[i % N_ZONE]) : (cell_flt[i] & ~loc_q[i]);
      zone_dis[i] = zone_q[i % N_ZONE];
    end
    for (int i = N_CELL-1; i >= 0; i--)
      if (fresh[i]) cell_idx = CW'(i);
  end

  assign cell_new = |fresh;
  assign cell_lvl = widen ? LVL_GROUP : LVL_LOCAL;
  assign glob_new = any_src & ~glob_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      loc_q  <= '0;
      zone_q <= '0;
    end else begin
      glob_q <= any_src | (glob_q & ~clr_req);
      loc_q  <= (cell_flt & {N_CELL{~widen}}) | (loc_q & ~({N_CELL{clr_req}} & ~cell_flt));
      zone_q <= (zone_flt & {N_ZONE{widen}}) | (zone_q & ~({N_ZONE{clr_req}} & ~zone_flt));
    end
  end

  assign glob_dis = glob_q;
  assign loc_dis  = loc_q;

  AST_GLOB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> glob_dis); // R2
  AST_GLOB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    glob_dis && !clr_req |=> glob_dis); // R4
endmodule

// File: rtl/bal_log_fifo.sv
module bal_log_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, acc, pop;

  assign full      = (cnt == (AW+1)'(DEPTH));
  assign acc       = push & ~full;
  assign out_valid = (cnt != '0);
  assign pop       = out_valid & out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (acc) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (acc) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(acc) - (AW+1)'(pop);
      if (push && full) ovf <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH)); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R11
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
endmodule

// File: rtl/bal_abort_arbiter.sv
module bal_abort_arbiter
  import bal_abort_pkg::*;
#(
  parameter int N_CELL    = 6,
  parameter int N_ZONE    = 2,
  parameter int TS_W      = 16,
  parameter int HB_W      = 16,
  parameter int LOG_DEPTH = 8,
  localparam int CW       = $clog2(N_CELL+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_present,
  input  logic              chg_fault,
  input  logic              in_uvlo,
  input  logic              temp_crit,
  input  logic              svc_mode,
  input  logic              cv_entry,
  input  logic              hb_pulse,
  input  logic [HB_W-1:0]   hb_limit,
  input  logic              zone_widen,
  input  logic              glob_clr,
  input  logic [N_CELL-1:0] cell_ov,
  input  logic [N_CELL-1:0] cell_uv,
  input  logic [N_CELL-1:0] cell_bad,
  input  logic [N_CELL-1:0] ch_en,
  input  logic [TS_W-1:0]   ts_now,
  output logic [N_CELL-1:0] loc_dis,
  output logic [N_CELL-1:0] zone_dis,
  output logic              glob_dis,
  output logic              log_valid,
  input  logic              log_ready,
  output logic [CW-1:0]     log_chan,
  output logic [TS_W-1:0]   log_start,
  output logic [TS_W-1:0]   log_stop,
  output logic [2:0]        log_reason,
  output logic [1:0]        log_level,
  output logic              log_ovf
);
  localparam int RW = CW + 2*TS_W + 3 + 2;

  logic                hb_lost;
  logic [NUM_GSRC-1:0] gsrc;
  logic [N_CELL-1:0]   cell_flt;
  logic                clr_req;
  logic                glob_new, cell_new;
  rsn_e                glob_rsn;
  lvl_e                cell_lvl;
  logic [CW-1:0]       cell_idx, open_idx;
  logic [TS_W-1:0]     open_start, cell_start;
  logic [N_CELL-1:0]   en_q;
  logic [TS_W-1:0]     start_q   [N_CELL];
  logic [TS_W-1:0]     eff_start [N_CELL];
  logic [RW-1:0]       rec, rec_out;

  bal_hb_watch #(.HB_W(HB_W)) u_hb (
    .clk(clk), .rst_n(rst_n), .hb_pulse(hb_pulse), .hb_limit(hb_limit), .hb_lost(hb_lost)
  );

  // bit order = priority order
  assign gsrc     = {svc_mode, hb_lost, chg_fault, temp_crit, (~chg_present) | in_uvlo};
  assign cell_flt = cell_ov | cell_uv | cell_bad;
  assign clr_req  = glob_clr | cv_entry;

  bal_shut_latch #(.N_CELL(N_CELL), .N_ZONE(N_ZONE), .CW(CW)) u_latch (
    .clk(clk), .rst_n(rst_n), .glob_src(gsrc), .cell_flt(cell_flt), .widen(zone_widen),
    .clr_req(clr_req), .glob_dis(glob_dis), .loc_dis(loc_dis), .zone_dis(zone_dis),
    .glob_new(glob_new), .glob_rsn(glob_rsn), .cell_new(cell_new), .cell_idx(cell_idx),
    .cell_lvl(cell_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= ch_en;
  end

  for (genvar g = 0; g < N_CELL; g++) begin : g_start
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   start_q[g] <= '0;
      else if (ch_en[g] && !en_q[g]) start_q[g] <= ts_now;
    end
    assign eff_start[g] = (ch_en[g] && !en_q[g]) ? ts_now : start_q[g];

    AST_LOCAL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cell_flt[g] && !zone_widen |=> loc_dis[g]); // R6
  end

  always_comb begin
    open_idx   = CW'(N_CELL);
    open_start = ts_now;
    cell_start = '0;
    for (int i = N_CELL-1; i >= 0; i--) begin
      if (ch_en[i]) begin
        open_idx   = CW'(i);
        open_start = eff_start[i];
      end
      if (cell_idx == CW'(i)) cell_start = eff_start[i];
    end
  end

  assign rec = glob_new ? {open_idx, open_start, ts_now, glob_rsn, LVL_GLOBAL}
                        : {cell_idx, cell_start, ts_now, RSN_CELL, cell_lvl};

  bal_log_fifo #(.W(RW), .DEPTH(LOG_DEPTH)) u_log (
    .clk(clk), .rst_n(rst_n), .push(glob_new | cell_new), .din(rec),
    .out_valid(log_valid), .out_ready(log_ready), .out_data(rec_out), .ovf(log_ovf)
  );

  assign {log_chan, log_start, log_stop, log_reason, log_level} = rec_out;
endmodule

// File: tb/test_bal_abort_arbiter.sv
module test_bal_abort_arbiter;
  localparam int N = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, chg_present, chg_fault, in_uvlo, temp_crit, svc_mode, cv_entry, hb_pulse;
  logic zone_widen, glob_clr, log_ready;
  logic [15:0] hb_limit;
  logic [N-1:0] cell_ov, cell_uv, cell_bad, ch_en;
  logic [15:0] tsv = '0;
  logic [N-1:0] loc_dis, zone_dis;
  logic glob_dis, log_valid, log_ovf;
  logic [2:0] log_chan, log_reason;
  logic [15:0] log_start, log_stop;
  logic [1:0] log_level;

  always @(posedge clk) tsv <= tsv + 1'b1;

  bal_abort_arbiter i_bal_abort_arbiter (
    .clk(clk), .rst_n(rst_n), .chg_present(chg_present), .chg_fault(chg_fault),
    .in_uvlo(in_uvlo), .temp_crit(temp_crit), .svc_mode(svc_mode), .cv_entry(cv_entry),
    .hb_pulse(hb_pulse), .hb_limit(hb_limit), .zone_widen(zone_widen), .glob_clr(glob_clr),
    .cell_ov(cell_ov), .cell_uv(cell_uv), .cell_bad(cell_bad), .ch_en(ch_en), .ts_now(tsv),
    .loc_dis(loc_dis), .zone_dis(zone_dis), .glob_dis(glob_dis), .log_valid(log_valid),
    .log_ready(log_ready), .log_chan(log_chan), .log_start(log_start), .log_stop(log_stop),
    .log_reason(log_reason), .log_level(log_level), .log_ovf(log_ovf)
  );

  typedef struct packed {
    logic [2:0] ch; logic [15:0] st; logic [15:0] sp; logic [2:0] rs; logic [1:0] lv;
  } rec_t;
  rec_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_rec(input logic [2:0] ch, input logic [15:0] st, input logic [15:0] sp,
                            input logic [2:0] rs, input logic [1:0] lv);
    rec_t r;
    r.ch = ch; r.st = st; r.sp = sp; r.rs = rs; r.lv = lv;
    exp_q.push_back(r);
  endtask

  // monitor: compare each record that is accepted at the next edge
  always @(negedge clk) begin
    if (rst_n && log_valid && log_ready) begin
      if (exp_q.size() == 0) chk("R9 unexpected record", {log_chan, log_start, log_stop, log_reason, log_level}, '0);
      else chk("R8 record", {log_chan, log_start, log_stop, log_reason, log_level}, exp_q.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic release_and_clear();
    chg_present = 1'b1; chg_fault = 1'b0; in_uvlo = 1'b0; temp_crit = 1'b0; svc_mode = 1'b0;
    glob_clr = 1'b1; tick(); glob_clr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] sa, s3, s1, v, v0;
    rst_n = 1'b0; chg_present = 1'b1; chg_fault = 1'b0; in_uvlo = 1'b0; temp_crit = 1'b0;
    svc_mode = 1'b0; cv_entry = 1'b0; hb_pulse = 1'b1; hb_limit = 16'd5; zone_widen = 1'b0;
    glob_clr = 1'b0; log_ready = 1'b1; cell_ov = '0; cell_uv = '0; cell_bad = '0; ch_en = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 loc_dis", loc_dis, 0);
    chk("R1 zone_dis", zone_dis, 0);
    chk("R1 glob_dis", glob_dis, 0);
    chk("R1 log_valid", log_valid, 0);
    chk("R1 log_ovf", log_ovf, 0);

    // R2 / R4: over-temperature, latch and clear policy
    ch_en = 6'b000100; sa = tsv; tick(); tick();
    temp_crit = 1'b1; v = tsv; expect_rec(3'd2, sa, v, 3'd2, 2'd3); tick();
    chk("R2 glob after overtemp", glob_dis, 1);
    glob_clr = 1'b1; tick(); glob_clr = 1'b0;
    chk("R4 clear ignored while source active", glob_dis, 1);
    temp_crit = 1'b0; tick();
    chk("R4 latched after source gone", glob_dis, 1);
    cv_entry = 1'b1; tick(); cv_entry = 1'b0;
    chk("R4 cv entry clears", glob_dis, 0);

    // R3: priority among simultaneous sources
    chg_present = 1'b0; temp_crit = 1'b1; svc_mode = 1'b1; v = tsv;
    expect_rec(3'd2, sa, v, 3'd1, 2'd3); tick();
    chk("R3 glob on charger gone", glob_dis, 1);
    release_and_clear();
    chk("R4 glob_clr clears", glob_dis, 0);
    chg_fault = 1'b1; svc_mode = 1'b1; v = tsv;
    expect_rec(3'd2, sa, v, 3'd3, 2'd3); tick();
    release_and_clear();
    in_uvlo = 1'b1; v = tsv;
    expect_rec(3'd2, sa, v, 3'd1, 2'd3); tick();
    chk("R2 glob on input undervoltage", glob_dis, 1);
    release_and_clear();

    // R5: heartbeat timeout after hb_limit+1 edges
    hb_pulse = 1'b0; v = tsv;
    repeat (5) tick();
    chk("R5 no timeout yet", glob_dis, 0);
    expect_rec(3'd2, sa, v + 16'd5, 3'd4, 2'd3); tick();
    chk("R5 timeout", glob_dis, 1);
    hb_pulse = 1'b1; tick();
    release_and_clear();
    chk("R5 released", glob_dis, 0);

    // R6: local stop
    ch_en = 6'b001100; s3 = tsv; tick();
    cell_uv[3] = 1'b1; v = tsv; expect_rec(3'd3, s3, v, 3'd6, 2'd1); tick();
    chk("R6 loc_dis", loc_dis, 6'b001000);
    chk("R6 zone untouched", zone_dis, 0);
    chk("R6 no global", glob_dis, 0);
    glob_clr = 1'b1; tick(); glob_clr = 1'b0;
    chk("R6 held while fault active", loc_dis, 6'b001000);
    cell_uv = '0; glob_clr = 1'b1; tick(); glob_clr = 1'b0;
    chk("R6 released", loc_dis, 0);

    // R7: zone widening
    zone_widen = 1'b1; ch_en = 6'b001110; s1 = tsv; tick();
    cell_bad[1] = 1'b1; v = tsv; expect_rec(3'd1, s1, v, 3'd6, 2'd2); tick();
    chk("R7 zone_dis odd cells", zone_dis, 6'b101010);
    chk("R7 loc_dis stays 0", loc_dis, 0);
    cell_bad = '0; glob_clr = 1'b1; tick(); glob_clr = 1'b0;
    chk("R7 zone released", zone_dis, 0);
    zone_widen = 1'b0; ch_en = '0; tick();

    // R9: one record per edge, global first, lowest cell
    svc_mode = 1'b1; cell_ov = 6'b010100; v = tsv; expect_rec(3'd6, v, v, 3'd5, 2'd3); tick();
    chk("R9 both cells latched", loc_dis, 6'b010100);
    tick();
    cell_ov = '0; release_and_clear();
    chk("R9 all released", {glob_dis, loc_dis}, 0);
    cell_ov = 6'b100001; v = tsv; expect_rec(3'd0, 16'd0, v, 3'd6, 2'd1); tick();
    chk("R9 two cells latched", loc_dis, 6'b100001);
    tick(); tick();
    chk("R9 single record drained", log_valid, 0);
    cell_ov = '0; glob_clr = 1'b1; tick(); glob_clr = 1'b0;

    // R10 / R11: back-pressure and overflow
    log_ready = 1'b0; v0 = tsv;
    for (int k = 0; k < 9; k++) begin
      svc_mode = 1'b1; v = tsv;
      if (k == 0) v0 = v;
      if (k < 8) expect_rec(3'd6, v, v, 3'd5, 2'd3);
      tick();
      svc_mode = 1'b0; glob_clr = 1'b1; tick(); glob_clr = 1'b0;
      if (k == 1) begin
        chk("R10 head valid under stall", log_valid, 1);
        chk("R10 head holds first record", log_stop, v0);
      end
      if (k == 7) chk("R11 no overflow at full", log_ovf, 0);
    end
    chk("R11 overflow set", log_ovf, 1);
    log_ready = 1'b1;
    repeat (12) tick();
    chk("R10 drained", log_valid, 0);
    chk("R11 overflow sticky", log_ovf, 1);
    chk("R11 dropped record absent", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule